// File: doc/BRIEF.md
# Prescaled Refresh Request Timer

This block paces refresh traffic for a memory controller. A programmable prescaler divides the system clock into ticks, and an 8-bit period counter counts those ticks. Each time the period counter wraps, the block hands exactly one refresh request to one memory bank. Only banks that are valid, mapped to this timer's bus and refresh-enabled can receive it.

Successive requests rotate among the banks that qualify. The search starts just after the bank served last and skips banks that do not qualify. A request is presented as a level with a bank index and stays until the controller acknowledges it. One further expiration can wait behind it as a single pending flag.

Software programs the prescale and period values through two write strobes. A period of zero turns the timer off. Running the command sequence, arbitrating for the bus and muxing addresses are left to the surrounding controller.

Top module: `rfsh_req_timer`

## Requirements
- R1: After synchronous reset, both programmed values are zero, `rfsh_req` is 0 and the timer is off.
- R2: With period P (1..255) and prescale S, expirations occur every (P+1)*(S+1) clock cycles. S=31 and P=11 give 384 cycles.
- R3: Bank i qualifies only when `bank_valid[i]`=1, `bank_bus_sel[i]`=0 (0 selects this timer's bus) and `bank_ref_en[i]`=1. A request is only ever issued to a bank that qualified in the cycle it was chosen.
- R4: The chosen bank is the first qualified bank found by searching upward, modulo 8, from the bank served last. The search includes that bank itself last. After reset the search starts at bank 0.
- R5: Each expiration yields at most one request. `rfsh_req` rises in the clock cycle after the expiration.
- R6: An expiration that finds no qualified bank is discarded, and the counters keep running.
- R7: `rfsh_req` and `rfsh_bank` hold steady until `rfsh_ack` is 1 while `rfsh_req` is 1. After that, `rfsh_req` falls on the next cycle unless a new request is issued.
- R8: An expiration arriving while a request is outstanding sets one pending flag, and further expirations are lost. The pending flag is served when the slot frees, or discarded if no bank qualifies at that moment.
- R9: A write to either register restarts both counters and suppresses any expiration in the write cycle. The first request after a write rises (P+1)*(S+1)+1 cycles after the cycle in which the write strobe is high.
- R10: While the period value is 0, no expiration and no request occur.
- R11: When an acknowledge and an expiration fall in the same cycle, the next request is presented on the following cycle with no idle cycle in between.
- R12: `rfsh_ack` while no request is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prescale_we | input | 1 | Write strobe for the prescale value |
| cfg_prescale_val | input | 8 | Prescale value S (divide by S+1) |
| cfg_period_we | input | 1 | Write strobe for the period value |
| cfg_period_val | input | 8 | Period value P (0 turns the timer off) |
| bank_valid | input | 8 | Per-bank valid flag |
| bank_bus_sel | input | 8 | Per-bank bus select, 0 = this timer's bus |
| bank_ref_en | input | 8 | Per-bank refresh enable |
| rfsh_req | output | 1 | Refresh request, held until acknowledged |
| rfsh_bank | output | 3 | Index of the bank to refresh |
| rfsh_ack | input | 1 | Acknowledge of the current request |

## Verification
A period expiration can coincide with the acknowledge of the previous request. It can also coincide with a still-outstanding request, in which case it must become the single pending flag. The bench provokes both on purpose with a two-cycle period. It acknowledges in exactly the expiring cycle, and it also withholds the acknowledge across several expirations. A behavioural model judges every cycle by tracking elapsed cycles, the pending flag and the rotation. Directed checks confirm that the request stays high with the next bank, and that only one extra request survives a long stall.

// File: rtl/rfsh_timer_pkg.sv
package rfsh_timer_pkg;

    localparam int RT_BANKS  = 8;
    localparam int RT_BANK_W = $clog2(RT_BANKS);

    typedef logic [RT_BANK_W-1:0] bank_idx_t;
    typedef logic [RT_BANKS-1:0]  bank_mask_t;

    typedef struct packed {
        logic      hit;
        bank_idx_t idx;
    } bank_pick_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ISSUE,
        ACT_DROP,
        ACT_DEFER
    } req_act_t;

    // Nearest qualified bank above 'last', wrapping; 'last' itself is tried last.
    function automatic bank_pick_t rr_pick(bank_idx_t last, bank_mask_t qual);
        bank_pick_t r;
        bank_idx_t  cand;
        r.hit = 1'b0;
        r.idx = last;
        for (int k = RT_BANKS; k >= 1; k--) begin
            cand = bank_idx_t'((int'(last) + k) % RT_BANKS);
            if (qual[cand]) begin
                r.hit = 1'b1;
                r.idx = cand;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
    parameter int PRE_W = 8,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_we,
    input  logic [PRE_W-1:0] pre_data,
    input  logic             per_we,
    input  logic [PER_W-1:0] per_data,
    output logic             expire_o
);

    logic [PRE_W-1:0] pre_q, pre_cnt;
    logic [PER_W-1:0] per_q, per_cnt;
    logic             wr, en, pre_wrap, per_wrap;

    assign wr       = pre_we | per_we;
    assign en       = (per_q != '0);
    assign pre_wrap = (pre_cnt == pre_q);
    assign per_wrap = (per_cnt == per_q);
    assign expire_o = en && !wr && pre_wrap && per_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            per_q   <= '0;
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (wr) begin
            if (pre_we) pre_q <= pre_data;
            if (per_we) per_q <= per_data;
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (en) begin
            if (pre_wrap) begin
                pre_cnt <= '0;
                per_cnt <= per_wrap ? '0 : per_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    // R2: counters never run past their programmed limits
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        (pre_cnt <= pre_q) && (per_cnt <= per_q));

    // R2: period is at least two cycles, so expirations never touch
    p_expire_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !expire_o);

    // R9: a reload cannot be followed by an immediate expiration
    p_reload_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        wr |=> !expire_o);

    // R10: a zero period stays silent
    p_off_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (per_q == '0 && !wr) |=> !expire_o);

endmodule

// File: rtl/rfsh_bank_qual.sv
module rfsh_bank_qual
    import rfsh_timer_pkg::*;
#(
    parameter logic BUS_ID = 1'b0
) (
    input  bank_mask_t valid_i,
    input  bank_mask_t bus_sel_i,
    input  bank_mask_t ref_en_i,
    input  bank_idx_t  last_i,
    output bank_mask_t qual_o,
    output bank_pick_t pick_o
);

    for (genvar g = 0; g < RT_BANKS; g++) begin : g_qual
        assign qual_o[g] = valid_i[g] && (bus_sel_i[g] == BUS_ID) && ref_en_i[g];
    end

    assign pick_o = rr_pick(last_i, qual_o);

endmodule

// File: rtl/rfsh_req_ctrl.sv
module rfsh_req_ctrl
    import rfsh_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       expire_i,
    input  bank_mask_t qual_i,
    input  bank_pick_t pick_i,
    input  logic       ack_i,
    output logic       req_valid_o,
    output bank_idx_t  req_bank_o,
    output bank_idx_t  last_o
);

    logic       pend_q;
    logic       slot_free, want;
    req_act_t   act;
    bank_mask_t qual_prev;

    assign slot_free = !req_valid_o || ack_i;
    assign want      = expire_i || pend_q;

    always_comb begin
        act = ACT_NONE;
        if (slot_free) begin
            if (want) act = pick_i.hit ? ACT_ISSUE : ACT_DROP;
        end else if (expire_i) begin
            act = ACT_DEFER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid_o <= 1'b0;
            req_bank_o  <= '0;
            last_o      <= bank_idx_t'(RT_BANKS - 1);
            pend_q      <= 1'b0;
            qual_prev   <= '0;
        end else begin
            qual_prev <= qual_i;
            case (act)
                ACT_ISSUE: begin
                    req_valid_o <= 1'b1;
                    req_bank_o  <= pick_i.idx;
                    last_o      <= pick_i.idx;
                    pend_q      <= pend_q && expire_i;
                end
                ACT_DROP: begin
                    req_valid_o <= 1'b0;
                    pend_q      <= 1'b0;
                end
                ACT_DEFER: pend_q <= 1'b1;
                default: if (slot_free) req_valid_o <= 1'b0;
            endcase
        end
    end

    // R7: an unacknowledged request holds its bank
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !ack_i) |=> (req_valid_o && $stable(req_bank_o)));

    // R8: a pending expiration only exists behind an outstanding request
    p_pend_behind_req_r8: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> req_valid_o);

    // R3: a fresh request targets a bank that qualified when chosen
    p_issue_qualified_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid_o) |-> qual_prev[req_bank_o]);

    // R12: a stray acknowledge with nothing due leaves the block idle
    p_idle_ack_r12: assert property (@(posedge clk) disable iff (rst)
        (!req_valid_o && !pend_q && !expire_i) |=> !req_valid_o);

endmodule

// File: rtl/rfsh_req_timer.sv
module rfsh_req_timer
    import rfsh_timer_pkg::*;
#(
    parameter int   PRE_W  = 8,
    parameter int   PER_W  = 8,
    parameter logic BUS_ID = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_prescale_we,
    input  logic [PRE_W-1:0]     cfg_prescale_val,
    input  logic                 cfg_period_we,
    input  logic [PER_W-1:0]     cfg_period_val,
    input  logic [RT_BANKS-1:0]  bank_valid,
    input  logic [RT_BANKS-1:0]  bank_bus_sel,
    input  logic [RT_BANKS-1:0]  bank_ref_en,
    output logic                 rfsh_req,
    output logic [RT_BANK_W-1:0] rfsh_bank,
    input  logic                 rfsh_ack
);

    logic       expire;
    bank_mask_t qual;
    bank_pick_t pick;
    bank_idx_t  last;

    rfsh_tick_gen #(.PRE_W(PRE_W), .PER_W(PER_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .pre_we   (cfg_prescale_we),
        .pre_data (cfg_prescale_val),
        .per_we   (cfg_period_we),
        .per_data (cfg_period_val),
        .expire_o (expire)
    );

    rfsh_bank_qual #(.BUS_ID(BUS_ID)) u_qual (
        .valid_i   (bank_valid),
        .bus_sel_i (bank_bus_sel),
        .ref_en_i  (bank_ref_en),
        .last_i    (last),
        .qual_o    (qual),
        .pick_o    (pick)
    );

    rfsh_req_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .expire_i    (expire),
        .qual_i      (qual),
        .pick_i      (pick),
        .ack_i       (rfsh_ack),
        .req_valid_o (rfsh_req),
        .req_bank_o  (rfsh_bank),
        .last_o      (last)
    );

    // R1: nothing is requested in the cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> !rfsh_req);

endmodule

// File: tb/test_rfsh_req_timer.sv
module test_rfsh_req_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_prescale_we = 1'b0;
    logic [7:0] cfg_prescale_val = '0;
    logic       cfg_period_we = 1'b0;
    logic [7:0] cfg_period_val = '0;
    logic [7:0] bank_valid = '0;
    logic [7:0] bank_bus_sel = '0;
    logic [7:0] bank_ref_en = '0;
    logic       rfsh_req;
    logic [2:0] rfsh_bank;
    logic       rfsh_ack = 1'b0;

    always #2.5 clk = ~clk;

    rfsh_req_timer i_rfsh_req_timer (
        .clk(clk), .rst(rst),
        .cfg_prescale_we(cfg_prescale_we), .cfg_prescale_val(cfg_prescale_val),
        .cfg_period_we(cfg_period_we), .cfg_period_val(cfg_period_val),
        .bank_valid(bank_valid), .bank_bus_sel(bank_bus_sel), .bank_ref_en(bank_ref_en),
        .rfsh_req(rfsh_req), .rfsh_bank(rfsh_bank), .rfsh_ack(rfsh_ack)
    );

    int  checks = 0, fails = 0, cyc = 0;
    bit  done = 0, auto_ack = 0, prev_v = 0;
    int  rises[$];
    int  served[$];

    // behavioural reference
    int  m_pre, m_per, m_el, m_bank, m_last, m_pick, m_span;
    bit  m_req, m_pend, m_wr, m_en, m_exp, m_free, m_want;

    function automatic bit is_qual(int i);
        return bank_valid[i] && !bank_bus_sel[i] && bank_ref_en[i];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_per = 0; m_el = 0; m_req = 0; m_bank = 0; m_pend = 0; m_last = 7;
        end else begin
            m_wr   = cfg_prescale_we || cfg_period_we;
            m_en   = (m_per != 0);
            m_span = (m_per + 1) * (m_pre + 1);
            m_exp  = m_en && !m_wr && (m_el == m_span - 1);
            m_pick = -1;
            for (int d = 1; d <= 8; d++)
                if (m_pick < 0 && is_qual((m_last + d) % 8)) m_pick = (m_last + d) % 8;
            m_free = !m_req || rfsh_ack;
            m_want = m_exp || m_pend;
            if (m_free) begin
                if (m_want && m_pick >= 0) begin
                    m_req = 1; m_bank = m_pick; m_last = m_pick; m_pend = m_pend && m_exp;
                end else begin
                    m_req = 0;
                    if (m_want) m_pend = 0;
                end
            end else if (m_exp) m_pend = 1;
            if (m_wr) begin
                if (cfg_prescale_we) m_pre = cfg_prescale_val;
                if (cfg_period_we)   m_per = cfg_period_val;
                m_el = 0;
            end else if (m_en) m_el = m_exp ? 0 : m_el + 1;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        check(rfsh_req === m_req, "R7", "model request level", int'(rfsh_req), int'(m_req));
        if (m_req) check(rfsh_bank === 3'(m_bank), "R4", "model bank", int'(rfsh_bank), m_bank);
        if (rfsh_req && !prev_v) rises.push_back(cyc);
        prev_v = rfsh_req;
        if (auto_ack) rfsh_ack = rfsh_req;
        if (rfsh_req && rfsh_ack) served.push_back(int'(rfsh_bank));
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        rst = 1; auto_ack = 0; rfsh_ack = 0;
        steps(3);
        rst = 0;
        step();
        rises.delete(); served.delete();
    endtask

    task automatic write_cfg(int pre, int per);
        cfg_prescale_we = 1; cfg_prescale_val = 8'(pre);
        cfg_period_we = 1;   cfg_period_val = 8'(per);
        step();
        cfg_prescale_we = 0; cfg_period_we = 0;
    endtask

    task automatic all_qual();
        bank_valid = 8'hFF; bank_bus_sel = 8'h00; bank_ref_en = 8'hFF;
    endtask

    initial begin
        int c0, b0;
        all_qual();
        do_reset();
        // R1 / R10: idle out of reset, period zero keeps it silent
        check(rfsh_req == 0, "R1", "request after reset", int'(rfsh_req), 0);
        steps(40);
        check(rises.size() == 0, "R10", "requests with zero period", rises.size(), 0);
        // R12: stray acknowledge while idle
        rfsh_ack = 1; step(); rfsh_ack = 0; step();
        check(rfsh_req == 0, "R12", "request after idle ack", int'(rfsh_req), 0);

        // R2 / R9: nominal 384-cycle period
        c0 = cyc;
        write_cfg(31, 11);
        auto_ack = 1;
        for (int i = 0; i < 1500 && rises.size() < 3; i++) step();
        check(rises.size() == 3, "R2", "rises seen", rises.size(), 3);
        if (rises.size() == 3) begin
            check(rises[0] == c0 + 385, "R9", "first rise after write", rises[0], c0 + 385);
            check(rises[1] - rises[0] == 384, "R2", "interval 1", rises[1] - rises[0], 384);
            check(rises[2] - rises[1] == 384, "R2", "interval 2", rises[2] - rises[1], 384);
        end
        // R9: rewrite mid-period restarts the count
        steps(100);
        rises.delete();
        c0 = cyc;
        write_cfg(3, 4);
        for (int i = 0; i < 100 && rises.size() < 1; i++) step();
        check(rises.size() == 1 && rises[0] == c0 + 21, "R9", "rise after rewrite",
              rises.size() ? rises[0] : -1, c0 + 21);

        // R3 / R4: rotation over a sparse qualified set {0,2,4,6,7}
        do_reset();
        bank_valid = 8'b1111_1101; bank_bus_sel = 8'b0010_0000; bank_ref_en = 8'b1111_0111;
        write_cfg(0, 1);
        auto_ack = 1;
        steps(24);
        begin
            int exp_seq[6] = '{0, 2, 4, 6, 7, 0};
            check(served.size() >= 6, "R4", "served count", served.size(), 6);
            for (int i = 0; i < 6 && i < served.size(); i++)
                check(served[i] == exp_seq[i], "R4", "rotation order", served[i], exp_seq[i]);
        end

        // R6: no qualified bank drops expirations, counting continues
        do_reset();
        bank_valid = 8'hFF; bank_bus_sel = 8'h00; bank_ref_en = 8'h00;
        write_cfg(0, 1);
        auto_ack = 1;
        steps(20);
        check(rises.size() == 0, "R6", "requests with no qualified bank", rises.size(), 0);
        bank_ref_en = 8'b0000_1000;
        steps(6);
        check(served.size() >= 1 && served[0] == 3, "R6", "bank after enabling",
              served.size() ? served[0] : -1, 3);

        // R7 / R8: stall across several expirations, only one survives
        do_reset();
        all_qual();
        write_cfg(0, 3);
        steps(20);
        check(rfsh_req == 1 && rfsh_bank == 0, "R7", "held request bank", int'(rfsh_bank), 0);
        cfg_period_we = 1; cfg_period_val = 0; step(); cfg_period_we = 0;
        rfsh_ack = 1; step(); rfsh_ack = 0;
        check(rfsh_req == 1 && rfsh_bank == 1, "R8", "pending served bank", int'(rfsh_bank), 1);
        rfsh_ack = 1; step(); rfsh_ack = 0;
        check(rfsh_req == 0, "R8", "no second queued request", int'(rfsh_req), 0);
        steps(10);
        check(rfsh_req == 0, "R8", "still idle after stall", int'(rfsh_req), 0);

        // R5 / R11: acknowledge in the expiring cycle
        do_reset();
        all_qual();
        write_cfg(0, 1);
        for (int i = 0; i < 20 && !rfsh_req; i++) step();
        check(rfsh_req == 1, "R5", "first request", int'(rfsh_req), 1);
        b0 = int'(rfsh_bank);
        step();
        rfsh_ack = 1; step(); rfsh_ack = 0;
        check(rfsh_req == 1 && rfsh_bank == 3'(b0 + 1), "R11", "back-to-back bank",
              int'(rfsh_bank), (b0 + 1) % 8);
        rfsh_ack = 1; step(); rfsh_ack = 0;
        steps(30);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule